// File: doc/BRIEF.md
# Two-Way Write-Back Cache with Virtual Set Select and Physical Tag Match

This block is a two-way set-associative cache controller with a write-back policy. A request brings a virtual byte address and, in the same cycle, the physical page number that a separate translation unit has produced for it. The set is chosen from virtual address bits. The two stored tags of that set are then compared against the physical page number. The set lookup can therefore run while translation is still in progress.

Each line holds eight bytes. Each way keeps a valid bit, a dirty bit and the full physical page number as its tag. Each set keeps one replacement bit that names its least recently used way. A hit is answered in the cycle after the request is taken. On a miss the controller picks a victim. If that victim is dirty, it is first written back to memory through a request/response port. The line is then refilled through the same port, and the access is replayed into the refilled line.

The default geometry has 512 sets. The index then spans virtual bits 11..3, so its top bit comes from the virtual page number. A constant output reports how many index bits lie above the 11-bit page offset.

Top module: `vipt_cache`

## Requirements
- R1: After reset every way is invalid, reqReady is high, respValid and memReqValid are low, and the first access to any address misses.
- R2: The set index is reqVaddr[3 +: log2(SETS)]. With the defaults this is bits 11..3, so addresses that differ only in bit 11 map to different sets. vpnIndexBits equals log2(SETS) minus 8, which is 1 by default.
- R3: A request taken while reqReady is high is answered with a one-cycle respValid. If its reqPtag matches the tag of a valid way in the selected set, the answer comes in the next cycle with respHit=1 and no memory traffic. At most one way matches.
- R4: A read returns on respRdata the byte at offset reqVaddr[2:0] of the line. Byte k occupies bits 8k+7..8k of the 64-bit line.
- R5: A write that hits replaces exactly the addressed byte and marks the way dirty. It causes no memory traffic.
- R6: On a miss the victim is way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the least recently used way.
- R7: Every hit and every refill leaves the replacement bit of the set pointing at the other way.
- R8: A dirty victim causes one memory write (memReqWrite=1) before the refill. Its memReqAddr is the physical block address {victim tag, reqVaddr[10:3]} and its memReqWdata is the victim's current line.
- R9: A clean or invalid victim causes no write. Every miss issues one memory read at {reqPtag, reqVaddr[10:3]}. The replayed access then answers with respHit=0 and the refilled data.
- R10: A write miss allocates the line, fills it from memory and then merges the byte, which leaves the line dirty.
- R11: Once memReqValid rises, it stays high with memReqWrite and memReqAddr unchanged until the cycle in which memRespValid is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request, taken when reqReady is high |
| reqWrite | input | 1 | 1 = byte write, 0 = byte read |
| reqVaddr | input | VA_W (20) | Virtual byte address |
| reqPtag | input | PTAG_W (13) | Physical page number for reqVaddr |
| reqWdata | input | 8 | Write byte |
| reqReady | output | 1 | Controller idle, request accepted this cycle |
| respValid | output | 1 | Access complete (one cycle) |
| respHit | output | 1 | Access hit without a refill |
| respRdata | output | 8 | Read byte |
| memReqValid | output | 1 | Memory request, held until response |
| memReqWrite | output | 1 | 1 = writeback of a dirty victim, 0 = refill read |
| memReqAddr | output | PTAG_W+8 (21) | Physical block address |
| memReqWdata | output | 64 | Writeback line |
| memRespValid | input | 1 | Memory response or write acknowledge |
| memRespData | input | 64 | Refill line |
| vpnIndexBits | output | 5 | Number of set-index bits taken from the virtual page number |

## Verification
The bench goes after the set-select boundary at bit 11. Three pages share a set when bit 11 is equal, but not when it differs. A design that indexed only inside the page offset would evict and miss where hits are due. Victim order is forced with fill-invalid-first and LRU sequences, since a wrong replacement bit shows up as an unexpected writeback or miss. A write-hit followed by eviction checks the writeback address and data and that the write precedes the refill; a lost dirty bit would skip the write and return stale data later. Write misses are then evicted to confirm that allocation leaves the line dirty.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WB,
    ST_FILL
  } ctrlState_t;

  // strobes from the controller into the datapath
  typedef struct packed {
    logic capture;      // latch the incoming request
    logic access;       // perform hit-side update (lru, dirty, byte write)
    logic latchVictim;  // remember the chosen victim way
    logic fill;         // install the refilled line
  } dpStrobe_t;

endpackage

// File: rtl/vipt_datapath.sv
module vipt_datapath
  import vipt_pkg::*;
#(
  parameter int VA_W      = 20,
  parameter int PTAG_W    = 13,
  parameter int SETS      = 512,
  parameter int BLK_BYTES = 8,
  parameter int PAGE_W    = 11,
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int IDX_W    = $clog2(SETS),
  localparam int LINE_W   = BLK_BYTES * 8,
  localparam int INPAGE_W = PAGE_W - OFF_W,
  localparam int MADDR_W  = PTAG_W + INPAGE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic                 reqWrite,
  input  logic [OFF_W+IDX_W-1:0] reqVaddrLow,
  input  logic [PTAG_W-1:0]    reqPtag,
  input  logic [7:0]           reqWdata,
  input  logic [LINE_W-1:0]    memRespData,
  output logic                 hit,
  output logic                 victimDirty,
  output logic [7:0]           respRdata,
  output logic [MADDR_W-1:0]   wbAddr,
  output logic [MADDR_W-1:0]   fillAddr,
  output logic [LINE_W-1:0]    wbData
);

  // captured request
  logic                curWrite;
  logic [IDX_W-1:0]    curSet;
  logic [OFF_W-1:0]    curOff;
  logic [PTAG_W-1:0]   curPtag;
  logic [7:0]          curWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWrite <= 1'b0;
      curSet   <= '0;
      curOff   <= '0;
      curPtag  <= '0;
      curWdata <= '0;
    end else if (strobe.capture) begin
      curWrite <= reqWrite;
      curSet   <= reqVaddrLow[OFF_W +: IDX_W];
      curOff   <= reqVaddrLow[OFF_W-1:0];
      curPtag  <= reqPtag;
      curWdata <= reqWdata;
    end
  end

  // tag store and data store
  logic [PTAG_W-1:0] tagMem   [SETS][2];
  logic [LINE_W-1:0] dataMem  [SETS*2];
  logic [1:0]        validMem [SETS];
  logic [1:0]        dirtyMem [SETS];
  logic              lruMem   [SETS];
  logic              victimWay;

  logic [1:0] wayHit;
  for (genvar w = 0; w < 2; w++) begin : g_way
    assign wayHit[w] = validMem[curSet][w] && (tagMem[curSet][w] == curPtag);
  end

  logic hitWay;
  assign hit    = |wayHit;
  assign hitWay = wayHit[1];

  logic victimSel;
  always_comb begin
    if (!validMem[curSet][0])      victimSel = 1'b0;
    else if (!validMem[curSet][1]) victimSel = 1'b1;
    else                           victimSel = lruMem[curSet];
  end
  assign victimDirty = validMem[curSet][victimSel] && dirtyMem[curSet][victimSel];

  logic [IDX_W:0] hitIdx;
  logic [IDX_W:0] vicIdx;
  assign hitIdx = {curSet, hitWay};
  assign vicIdx = {curSet, victimWay};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        dirtyMem[s] <= '0;
        lruMem[s]   <= 1'b0;
      end
      victimWay <= 1'b0;
    end else begin
      if (strobe.latchVictim) victimWay <= victimSel;
      if (strobe.access) begin
        lruMem[curSet] <= ~hitWay;
        if (curWrite) dirtyMem[curSet][hitWay] <= 1'b1;
      end
      if (strobe.fill) begin
        validMem[curSet][victimWay] <= 1'b1;
        dirtyMem[curSet][victimWay] <= 1'b0;
        lruMem[curSet]              <= ~victimWay;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      dataMem[vicIdx]             <= memRespData;
      tagMem[curSet][victimWay]   <= curPtag;
    end
    if (strobe.access && curWrite)
      dataMem[hitIdx][{curOff, 3'b000} +: 8] <= curWdata;
  end

  logic [LINE_W-1:0] hitLine;
  assign hitLine   = dataMem[hitIdx];
  assign respRdata = hitLine[{curOff, 3'b000} +: 8];
  assign wbAddr    = {tagMem[curSet][victimWay], curSet[INPAGE_W-1:0]};
  assign fillAddr  = {curPtag, curSet[INPAGE_W-1:0]};
  assign wbData    = dataMem[vicIdx];

  // R3
  single_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wayHit));

  // R7
  lru_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |=> (lruMem[curSet] != victimWay));

endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      hit,
  input  logic      victimDirty,
  input  logic      memRespValid,
  output dpStrobe_t strobe,
  output logic      reqReady,
  output logic      respValid,
  output logic      respHit,
  output logic      memReqValid,
  output logic      memReqWrite
);

  ctrlState_t state;
  ctrlState_t stateNext;
  logic       missSeen;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    reqReady    = 1'b0;
    respValid   = 1'b0;
    respHit     = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          strobe.access = 1'b1;
          respValid     = 1'b1;
          respHit       = !missSeen;
          stateNext     = ST_IDLE;
        end else begin
          strobe.latchVictim = 1'b1;
          stateNext          = victimDirty ? ST_WB : ST_FILL;
        end
      end
      ST_WB: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memRespValid) stateNext = ST_FILL;
      end
      ST_FILL: begin
        memReqValid = 1'b1;
        if (memRespValid) begin
          strobe.fill = 1'b1;
          stateNext   = ST_LOOKUP;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      missSeen <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.capture)          missSeen <= 1'b0;
      else if (strobe.latchVictim) missSeen <= 1'b1;
    end
  end

  // R3
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  // R8
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && memRespValid) |=> (memReqValid && !memReqWrite));

  // R9
  miss_replay_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |=> (respValid && !respHit));

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_pkg::*;
#(
  parameter int VA_W      = 20,
  parameter int PTAG_W    = 13,
  parameter int SETS      = 512,
  parameter int BLK_BYTES = 8,
  parameter int PAGE_W    = 11,
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int IDX_W    = $clog2(SETS),
  localparam int LINE_W   = BLK_BYTES * 8,
  localparam int INPAGE_W = PAGE_W - OFF_W,
  localparam int MADDR_W  = PTAG_W + INPAGE_W,
  localparam int CNT_W    = $clog2(VA_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic [PTAG_W-1:0]  reqPtag,
  input  logic [7:0]         reqWdata,
  output logic               reqReady,
  output logic               respValid,
  output logic               respHit,
  output logic [7:0]         respRdata,
  output logic               memReqValid,
  output logic               memReqWrite,
  output logic [MADDR_W-1:0] memReqAddr,
  output logic [LINE_W-1:0]  memReqWdata,
  input  logic               memRespValid,
  input  logic [LINE_W-1:0]  memRespData,
  output logic [CNT_W-1:0]   vpnIndexBits
);

  dpStrobe_t          strobe;
  logic               hit;
  logic               victimDirty;
  logic [MADDR_W-1:0] wbAddr;
  logic [MADDR_W-1:0] fillAddr;

  // upper virtual bits take no part in set selection
  logic unusedVaBits;
  assign unusedVaBits = ^reqVaddr[VA_W-1:OFF_W+IDX_W];

  vipt_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .hit         (hit),
    .victimDirty (victimDirty),
    .memRespValid(memRespValid),
    .strobe      (strobe),
    .reqReady    (reqReady),
    .respValid   (respValid),
    .respHit     (respHit),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite)
  );

  vipt_datapath #(
    .VA_W     (VA_W),
    .PTAG_W   (PTAG_W),
    .SETS     (SETS),
    .BLK_BYTES(BLK_BYTES),
    .PAGE_W   (PAGE_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqWrite   (reqWrite),
    .reqVaddrLow(reqVaddr[OFF_W+IDX_W-1:0]),
    .reqPtag    (reqPtag),
    .reqWdata   (reqWdata),
    .memRespData(memRespData),
    .hit        (hit),
    .victimDirty(victimDirty),
    .respRdata  (respRdata),
    .wbAddr     (wbAddr),
    .fillAddr   (fillAddr),
    .wbData     (memReqWdata)
  );

  assign memReqAddr   = memReqWrite ? wbAddr : fillAddr;
  assign vpnIndexBits = CNT_W'(IDX_W - INPAGE_W);

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRespValid) |=>
      (memReqValid && $stable(memReqWrite) && $stable(memReqAddr)));

  // R1
  idle_no_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady);

endmodule

// File: tb/vipt_cache_bench.sv
module vipt_cache_bench;
  localparam int VA_W = 20, PTAG_W = 13, SETS = 512, MADDR_W = 21, MEM_LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic              reqValid = 1'b0, reqWrite = 1'b0;
  logic [VA_W-1:0]   reqVaddr = '0;
  logic [PTAG_W-1:0] reqPtag = '0;
  logic [7:0]        reqWdata = '0;
  logic              reqReady, respValid, respHit;
  logic [7:0]        respRdata;
  logic              memReqValid, memReqWrite;
  logic [MADDR_W-1:0] memReqAddr;
  logic [63:0]       memReqWdata;
  logic              memRespValid = 1'b0;
  logic [63:0]       memRespData = '0;
  logic [4:0]        vpnIndexBits;

  vipt_cache #(.VA_W(VA_W), .PTAG_W(PTAG_W), .SETS(SETS)) u_vipt_cache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqVaddr(reqVaddr), .reqPtag(reqPtag), .reqWdata(reqWdata),
    .reqReady(reqReady), .respValid(respValid), .respHit(respHit),
    .respRdata(respRdata), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .vpnIndexBits(vpnIndexBits)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // translation used by the bench: injective, so no aliasing
  function automatic logic [PTAG_W-1:0] ptagOf(input logic [VA_W-1:0] va);
    return {4'b1010, va[19:11] ^ 9'h155};
  endfunction
  function automatic logic [MADDR_W-1:0] blkOf(input logic [VA_W-1:0] va);
    return {ptagOf(va), va[10:3]};
  endfunction
  function automatic logic [63:0] initBlock(input logic [MADDR_W-1:0] a);
    return {32'(a) * 32'h9E3779B1, 32'(a) ^ 32'h5A5A1234};
  endfunction

  logic [63:0] shadowMem [int];
  logic [63:0] memStore  [int];

  function automatic logic [63:0] shadowGet(input logic [MADDR_W-1:0] a);
    if (shadowMem.exists(int'(a))) return shadowMem[int'(a)];
    return initBlock(a);
  endfunction
  function automatic logic [63:0] storeGet(input logic [MADDR_W-1:0] a);
    if (memStore.exists(int'(a))) return memStore[int'(a)];
    return initBlock(a);
  endfunction

  // reference tag store
  bit                mValid [SETS][2];
  bit                mDirty [SETS][2];
  logic [PTAG_W-1:0] mTag   [SETS][2];
  bit                mLru   [SETS];

  // memory responder, acts on falling edges
  int                 wbCnt = 0, fillCnt = 0, memWait = 0;
  bit                 wbAfterFill = 0;
  logic [MADDR_W-1:0] lastWbAddr = '0, lastFillAddr = '0, firstAddr = '0;
  logic               firstWrite = 1'b0;

  always @(negedge clk) begin
    if (!rstN) begin
      memRespValid = 1'b0;
      memWait = 0;
    end else if (memRespValid) begin
      memRespValid = 1'b0;
    end else if (memReqValid) begin
      if (memWait == 0) begin
        firstAddr  = memReqAddr;
        firstWrite = memReqWrite;
      end
      if (memWait == MEM_LAT) begin
        memWait = 0;
        check("R11 request held", {firstWrite, firstAddr}, {memReqWrite, memReqAddr});
        if (memReqWrite) begin
          wbCnt++;
          lastWbAddr = memReqAddr;
          if (fillCnt != 0) wbAfterFill = 1;
          check("R8 writeback data", memReqWdata, shadowGet(memReqAddr));
          memStore[int'(memReqAddr)] = memReqWdata;
        end else begin
          fillCnt++;
          lastFillAddr = memReqAddr;
          memRespData = storeGet(memReqAddr);
        end
        memRespValid = 1'b1;
      end else begin
        memWait++;
      end
    end
  end

  task automatic doAccess(input bit wr, input logic [VA_W-1:0] va, input logic [7:0] wd,
                          input string tag);
    logic [PTAG_W-1:0]  pt = ptagOf(va);
    int                 s = int'(va[11:3]);
    bit                 expHit = 0, expWb = 0;
    int                 hw = 0;
    logic [MADDR_W-1:0] expWbAddr = '0;
    logic [63:0]        blk;
    logic [7:0]         expByte;
    for (int w = 0; w < 2; w++)
      if (mValid[s][w] && mTag[s][w] == pt) begin expHit = 1; hw = w; end
    if (!expHit) begin
      hw = !mValid[s][0] ? 0 : (!mValid[s][1] ? 1 : int'(mLru[s]));
      expWb = mValid[s][hw] && mDirty[s][hw];
      expWbAddr = {mTag[s][hw], va[10:3]};
      mValid[s][hw] = 1; mDirty[s][hw] = 0; mTag[s][hw] = pt;
    end
    mLru[s] = (hw == 0);
    if (wr) mDirty[s][hw] = 1;
    blk = shadowGet(blkOf(va));
    expByte = blk[{va[2:0], 3'b000} +: 8];
    wbCnt = 0; fillCnt = 0; wbAfterFill = 0;

    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqVaddr = va; reqPtag = pt; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    while (!respValid) @(negedge clk);

    check({"R3/R9 ", tag, " hit flag"}, 64'(respHit), 64'(expHit));
    if (!wr) check({"R4 ", tag, " read byte"}, 64'(respRdata), 64'(expByte));
    else begin
      blk[{va[2:0], 3'b000} +: 8] = wd;
      shadowMem[int'(blkOf(va))] = blk;
    end
    check({"R6/R8 ", tag, " writeback count"}, 64'(wbCnt), 64'(expWb));
    if (expWb) begin
      check({"R8 ", tag, " writeback addr"}, 64'(lastWbAddr), 64'(expWbAddr));
      check({"R8 ", tag, " writeback before refill"}, 64'(wbAfterFill), 64'd0);
    end
    check({"R9 ", tag, " refill count"}, 64'(fillCnt), 64'(!expHit));
    if (!expHit) check({"R9 ", tag, " refill addr"}, 64'(lastFillAddr), 64'(blkOf(va)));
  endtask

  function automatic logic [VA_W-1:0] mkVa(input int vpn, input int inPage);
    return {9'(vpn), 11'(inPage)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reqReady after reset", 64'(reqReady), 64'd1);
    check("R1 respValid after reset", 64'(respValid), 64'd0);
    check("R1 memReqValid after reset", 64'(memReqValid), 64'd0);
    // R2 status count
    check("R2 vpnIndexBits", 64'(vpnIndexBits), 64'd1);

    // R1 R9 R6: first access misses into invalid way 0
    doAccess(0, mkVa(0, 'h100), 8'h00, "R1 first read A");
    doAccess(0, mkVa(0, 'h104), 8'h00, "R3 read A again");
    // R5 write hit, no traffic
    doAccess(1, mkVa(0, 'h105), 8'hC3, "R5 write hit A");
    doAccess(0, mkVa(0, 'h105), 8'h00, "R5 readback A");
    // R6 second tag into invalid way 1
    doAccess(0, mkVa(2, 'h100), 8'h00, "R6 read B");
    // R7 R8 third tag evicts LRU way holding dirty A
    doAccess(0, mkVa(4, 'h100), 8'h00, "R8 read C evicts A");
    // R7: A now replaces clean B
    doAccess(0, mkVa(0, 'h105), 8'h00, "R7 read A refill");
    // R2 bit 11 separates sets
    doAccess(0, mkVa(8, 'h200), 8'h00, "R2 read X");
    doAccess(0, mkVa(9, 'h200), 8'h00, "R2 read Y");
    doAccess(0, mkVa(10, 'h200), 8'h00, "R2 read Z");
    doAccess(0, mkVa(8, 'h200), 8'h00, "R2 X still held");
    doAccess(0, mkVa(9, 'h200), 8'h00, "R2 Y still held");
    // R10 write miss allocates dirty line
    doAccess(1, mkVa(16, 'h302), 8'h5A, "R10 write miss W");
    doAccess(0, mkVa(18, 'h300), 8'h00, "R10 read V1");
    doAccess(0, mkVa(20, 'h300), 8'h00, "R10 read V2 evicts W");
    doAccess(0, mkVa(16, 'h302), 8'h00, "R10 W data returns");

    for (int i = 0; i < 1500; i++) begin
      int vpn = int'($urandom_range(0, 7));
      int low = 'h80 + int'($urandom_range(0, 1));
      int off = int'($urandom_range(0, 7));
      bit wr = ($urandom_range(0, 2) == 0);
      doAccess(wr, mkVa(vpn, (low << 3) | off), 8'($urandom), "R6/R7 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule